// File: doc/BRIEF.md
# Escalating Timebase Watchdog

This block is a processor-style watchdog that watches a free-running 64-bit timebase. The period field of a control register picks one timebase bit. Each time that bit goes from 0 to 1, the block records one expiry event. A two-bit status register counts these events through three stages:

- The first expiry sets an arm flag.
- The second expiry sets an interrupt flag.
- The third expiry is the final one. It may issue a reset request carrying the reset code from the control register.

Software keeps the system alive by clearing the status flags before the sequence reaches the end.

After the final expiry the block stops watching the timebase. It starts watching again only when software writes the control register or writes the status register. The interrupt output is the control-register interrupt enable ANDed with the interrupt flag. An external enable input decides whether a final expiry may request a reset at all. Arbitration of the interrupt and the reset action itself are handled elsewhere.

Top module: `wdt_escalator`

## Requirements
- R1: During and after a synchronous reset, the status flags are 00, `irq_o` is 0, `rst_req_o` is 0 and `rst_code_o` is 00. The control register resets to all zeros.
- R2: The period P is 6 bits: P[1:0] = ctl[31:30] and P[5:2] = ctl[20:17]. When parameter `USE_EXT` is 0, only ctl[31:30] is used and the upper bits are zero. An expiry is a 0-to-1 change of timebase bit 63−P between two consecutive clocks. Its effect on the status outputs appears one clock after the new timebase value is sampled.
- R3: An expiry while the arm flag (`sts_o[1]`) is 0 sets the arm flag. The interrupt flag (`sts_o[0]`) is left as it is.
- R4: An expiry while the arm flag is 1 and the interrupt flag is 0 sets the interrupt flag.
- R5: `irq_o` equals ctl[27] AND the interrupt flag. It follows either of them one clock after a write or an expiry.
- R6: An expiry while both flags are 1 is final. If `wd_en` is 1 and the reset code ctl[29:28] is not 00, `rst_req_o` is high for exactly one clock and `rst_code_o` carries the code. When the request is low, `rst_code_o` is 00.
- R7: A final expiry with `wd_en` low, or with reset code 00, produces no reset request.
- R8: After a final expiry, further selected-bit rises are ignored. Watching resumes after a control write, or after a status write whose data has either bit set.
- R9: Status writes use data bit 1 for the arm flag and data bit 0 for the interrupt flag. A set strobe ORs the data in. A clear strobe removes the bits that are 1 in the data. If both strobes are active, the clear is applied after the set.
- R10: A status write whose data has any bit set overrides an expiry in the same clock. That expiry is dropped entirely.
- R11: In the clock after the period value changes, no expiry is detected, even if the newly selected bit is 1 and the previously selected bit was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbase | input | 64 | Free-running timebase value |
| wd_en | input | 1 | Permits a final expiry to request reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| sts_set_we | input | 1 | Status write-one-to-set strobe |
| sts_clr_we | input | 1 | Status write-one-to-clear strobe |
| sts_wdata | input | 2 | Status write data: {arm, interrupt} |
| ctl_o | output | 32 | Control register contents |
| sts_o | output | 2 | Status flags {arm, interrupt} |
| irq_o | output | 1 | Watchdog interrupt request |
| rst_req_o | output | 1 | One-clock reset request pulse |
| rst_code_o | output | 2 | Reset code accompanying the request |

## Verification
The assertions assume that the timebase changes at most once per clock. They also assume that the selected bit can only rise again after it has been seen low for at least one clock; this is what makes the reset request a single clock wide. The stimulus advances the timebase by small increments each clock. It selects periods that land on the low bits so that many expiries occur. Control and status writes are applied at low rates, and directed sequences cover the final-expiry freeze, same-clock clear and period-change cases.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CTL_W   = 32;
  localparam int TB_W    = 64;
  localparam int PER_W   = 6;
  localparam int PLO_HI  = 31;
  localparam int PLO_LO  = 30;
  localparam int PHI_HI  = 20;
  localparam int PHI_LO  = 17;
  localparam int CODE_HI = 29;
  localparam int CODE_LO = 28;
  localparam int IE_BIT  = 27;

  typedef struct packed {
    logic arm;
    logic ist;
  } wdt_sts_t;

  function automatic logic [PER_W-1:0] period_of(input logic [CTL_W-1:0] c, input bit ext);
    logic [PER_W-1:0] p;
    p = '0;
    p[1:0] = c[PLO_HI:PLO_LO];
    if (ext) p[PER_W-1:2] = c[PHI_HI:PHI_LO];
    return p;
  endfunction
endpackage

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
  import wdt_pkg::*;
#(
  parameter bit USE_EXT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [PER_W-1:0] period,
  output logic [1:0]       code,
  output logic             ie_next
);
  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else if (we) ctl_q <= wdata;
  end

  always_comb begin
    period  = period_of(ctl_q, USE_EXT);
    code    = ctl_q[CODE_HI:CODE_LO];
    ie_next = we ? wdata[IE_BIT] : ctl_q[IE_BIT];
  end
endmodule

// File: rtl/wdt_tick_det.sv
module wdt_tick_det
  import wdt_pkg::*;
#(
  parameter int TBW = TB_W,
  parameter int PW  = PER_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [TBW-1:0] tbase,
  input  logic [PW-1:0]  period,
  input  logic           frozen,
  output logic           tick
);
  localparam int IW = (TBW > 1) ? $clog2(TBW) : 1;

  logic [IW-1:0] idx;
  logic          sel;
  logic          sel_q;
  logic [PW-1:0] per_q;

  always_comb begin
    idx  = IW'(TBW - 1) - IW'(period);
    sel  = tbase[idx];
    tick = sel & ~sel_q & (period == per_q) & ~frozen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      per_q <= '0;
    end else begin
      sel_q <= sel;
      per_q <= period;
    end
  end
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       set_we,
  input  logic       clr_we,
  input  logic [1:0] wdata,
  input  logic       ctl_we,
  input  logic       ie_next,
  input  logic [1:0] code,
  input  logic       wd_en,
  output wdt_sts_t   sts,
  output logic       frozen,
  output logic       irq,
  output logic       rst_req,
  output logic [1:0] rst_code
);
  wdt_sts_t nxt;
  logic     wr_hit;
  logic     final_x;
  logic     fire;

  always_comb begin
    wr_hit  = (set_we | clr_we) & (|wdata);
    final_x = tick & sts.arm & sts.ist & ~wr_hit;
    fire    = final_x & wd_en & (|code);
    nxt     = sts;
    if (wr_hit) begin
      if (set_we) nxt = wdt_sts_t'(nxt | wdata);
      if (clr_we) nxt = wdt_sts_t'(nxt & ~wdata);
    end else if (tick) begin
      if (!sts.arm)      nxt.arm = 1'b1;
      else if (!sts.ist) nxt.ist = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts      <= '0;
      frozen   <= 1'b0;
      irq      <= 1'b0;
      rst_req  <= 1'b0;
      rst_code <= 2'b00;
    end else begin
      sts      <= nxt;
      frozen   <= (ctl_we | wr_hit) ? 1'b0 : (final_x ? 1'b1 : frozen);
      irq      <= ie_next & nxt.ist;
      rst_req  <= fire;
      rst_code <= fire ? code : 2'b00;
    end
  end
endmodule

// File: rtl/wdt_escalator.sv
module wdt_escalator
  import wdt_pkg::*;
#(
  parameter bit USE_EXT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TB_W-1:0]  tbase,
  input  logic             wd_en,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             sts_set_we,
  input  logic             sts_clr_we,
  input  logic [1:0]       sts_wdata,
  output logic [CTL_W-1:0] ctl_o,
  output logic [1:0]       sts_o,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic [1:0]       rst_code_o
);
  logic [PER_W-1:0] period;
  logic [1:0]       code;
  logic             ie_next;
  logic             tick;
  logic             frozen;
  wdt_sts_t         sts;

  wdt_ctl_reg #(.USE_EXT(USE_EXT)) u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
    .ctl_q(ctl_o), .period(period), .code(code), .ie_next(ie_next)
  );

  wdt_tick_det #(.TBW(TB_W), .PW(PER_W)) u_det (
    .clk(clk), .rst(rst), .tbase(tbase), .period(period),
    .frozen(frozen), .tick(tick)
  );

  wdt_stage u_stg (
    .clk(clk), .rst(rst), .tick(tick), .set_we(sts_set_we),
    .clr_we(sts_clr_we), .wdata(sts_wdata), .ctl_we(ctl_we),
    .ie_next(ie_next), .code(code), .wd_en(wd_en), .sts(sts),
    .frozen(frozen), .irq(irq_o), .rst_req(rst_req_o), .rst_code(rst_code_o)
  );

  assign sts_o = {sts.arm, sts.ist};
endmodule

// File: rtl/wdt_escalator_chk.sv
module wdt_escalator_chk (
  input logic        clk,
  input logic        rst,
  input logic        wd_en,
  input logic        sts_set_we,
  input logic        sts_clr_we,
  input logic [1:0]  sts_wdata,
  input logic [31:0] ctl_o,
  input logic [1:0]  sts_o,
  input logic        irq_o,
  input logic        rst_req_o,
  input logic [1:0]  rst_code_o
);
  p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (sts_o[0] && ctl_o[27]));
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);
  p_code_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> (rst_code_o != 2'b00));
  p_code_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !rst_req_o |-> (rst_code_o == 2'b00));
  p_enable_gate_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> $past(wd_en));
  p_final_stage_r6: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> ($past(sts_o) == 2'b11));
  p_clear_wins_r10: assert property (@(posedge clk) disable iff (rst)
    $past(sts_clr_we && sts_wdata[0] && !sts_set_we) |-> !sts_o[0]);
endmodule

bind wdt_escalator wdt_escalator_chk u_chk (
  .clk(clk), .rst(rst), .wd_en(wd_en), .sts_set_we(sts_set_we),
  .sts_clr_we(sts_clr_we), .sts_wdata(sts_wdata), .ctl_o(ctl_o),
  .sts_o(sts_o), .irq_o(irq_o), .rst_req_o(rst_req_o), .rst_code_o(rst_code_o)
);

// File: tb/sim_wdt_escalator.sv
module sim_wdt_escalator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] tbase = '0;
  logic        wd_en = 1'b1;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        sts_set_we = 1'b0;
  logic        sts_clr_we = 1'b0;
  logic [1:0]  sts_wdata = '0;
  logic [31:0] ctl_o;
  logic [1:0]  sts_o;
  logic        irq_o;
  logic        rst_req_o;
  logic [1:0]  rst_code_o;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // model state
  logic [31:0] m_ctl;
  logic        m_prev;
  logic [5:0]  m_perq;
  logic        m_arm, m_ist, m_frz, m_irq, m_req;
  logic [1:0]  m_code;

  always #10 clk = ~clk;

  wdt_escalator u0 (
    .clk(clk), .rst(rst), .tbase(tbase), .wd_en(wd_en), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .sts_set_we(sts_set_we), .sts_clr_we(sts_clr_we),
    .sts_wdata(sts_wdata), .ctl_o(ctl_o), .sts_o(sts_o), .irq_o(irq_o),
    .rst_req_o(rst_req_o), .rst_code_o(rst_code_o)
  );

  function automatic logic [5:0] per_fn(input logic [31:0] c);
    return {c[20:17], c[31:30]};
  endfunction

  function automatic logic [31:0] mk_ctl(input logic [5:0] p, input logic [1:0] code, input logic ie);
    logic [31:0] c;
    c = '0;
    c[31:30] = p[1:0];
    c[20:17] = p[5:2];
    c[29:28] = code;
    c[27] = ie;
    return c;
  endfunction

  task automatic model_reset();
    m_ctl = '0; m_prev = 0; m_perq = '0;
    m_arm = 0; m_ist = 0; m_frz = 0; m_irq = 0; m_req = 0; m_code = 0;
  endtask

  task automatic model_step();
    logic [5:0] p;
    logic sel, tk, hit, fin;
    logic [1:0] s;
    p   = per_fn(m_ctl);
    sel = tbase[63 - p];
    tk  = sel && !m_prev && (p == m_perq) && !m_frz;
    hit = (sts_set_we || sts_clr_we) && (sts_wdata != 2'b00);
    fin = tk && m_arm && m_ist && !hit;
    s = {m_arm, m_ist};
    if (hit) begin
      if (sts_set_we) s = s | sts_wdata;
      if (sts_clr_we) s = s & ~sts_wdata;
    end else if (tk) begin
      if (!s[1]) s[1] = 1'b1;
      else if (!s[0]) s[0] = 1'b1;
    end
    m_req  = fin && wd_en && (m_ctl[29:28] != 2'b00);
    m_code = m_req ? m_ctl[29:28] : 2'b00;
    m_frz  = (ctl_we || hit) ? 1'b0 : (fin ? 1'b1 : m_frz);
    m_prev = sel;
    m_perq = p;
    if (ctl_we) m_ctl = ctl_wdata;
    {m_arm, m_ist} = s;
    m_irq = m_ctl[27] && s[0];
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    check({30'b0, sts_o}, {30'b0, m_arm, m_ist}, "status");
    check({31'b0, irq_o}, {31'b0, m_irq}, "irq");
    check({31'b0, rst_req_o}, {31'b0, m_req}, "rst_req");
    check({30'b0, rst_code_o}, {30'b0, m_code}, "rst_code");
    check(ctl_o, m_ctl, "ctl");
  endtask

  // one clock: inputs already applied at negedge
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    ctl_we = 0; sts_set_we = 0; sts_clr_we = 0; sts_wdata = '0;
  endtask

  task automatic wr_ctl(input logic [31:0] c);
    ctl_we = 1; ctl_wdata = c; step();
  endtask

  task automatic bit0(input logic v);
    tbase[0] = v; step();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    compare();

    // R3 R4 R5 R6: escalate on bit 0 (P=63), code 01, interrupt enabled
    wr_ctl(mk_ctl(6'd63, 2'b01, 1'b1));
    step();
    cur_req = "R3"; bit0(1);
    check({30'b0, sts_o}, 32'd2, "first expiry arm only R3");
    bit0(0);
    cur_req = "R4"; bit0(1);
    check({30'b0, sts_o}, 32'd3, "second expiry R4");
    cur_req = "R5"; check({31'b0, irq_o}, 32'd1, "irq raised R5");
    bit0(0);
    cur_req = "R6"; bit0(1);
    check({31'b0, rst_req_o}, 32'd1, "final pulse R6");
    check({30'b0, rst_code_o}, 32'd1, "code R6");
    bit0(0);
    check({31'b0, rst_req_o}, 32'd0, "pulse ends R6");
    cur_req = "R8"; bit0(1); bit0(0); bit0(1);
    check({31'b0, rst_req_o}, 32'd0, "frozen no pulse R8");
    // R9: clear interrupt flag, resume
    cur_req = "R9"; sts_clr_we = 1; sts_wdata = 2'b01; step();
    check({30'b0, sts_o}, 32'd2, "w1c interrupt R9");
    check({31'b0, irq_o}, 32'd0, "irq drops R5");
    bit0(0);
    cur_req = "R8"; bit0(1);
    check({30'b0, sts_o}, 32'd3, "resumed after write R8");
    cur_req = "R9"; sts_set_we = 1; sts_clr_we = 1; sts_wdata = 2'b11; step();
    check({30'b0, sts_o}, 32'd0, "set then clear R9");

    // R7: wd_en low, then code 00
    cur_req = "R7"; wd_en = 0;
    sts_set_we = 1; sts_wdata = 2'b11; step();
    bit0(0); bit0(1);
    check({31'b0, rst_req_o}, 32'd0, "wd_en low R7");
    wd_en = 1; wr_ctl(mk_ctl(6'd63, 2'b00, 1'b0));
    bit0(0); bit0(1);
    check({31'b0, rst_req_o}, 32'd0, "code 00 R7");

    // R10: clear with expiry same clock
    cur_req = "R10"; sts_clr_we = 1; sts_wdata = 2'b11; step();
    bit0(0);
    tbase[0] = 1; sts_clr_we = 1; sts_wdata = 2'b01; step();
    check({30'b0, sts_o}, 32'd0, "clear beats expiry R10");

    // R11: period change to a bit already high
    cur_req = "R11"; tbase = 64'h0000_0000_0000_0020; step();
    wr_ctl(mk_ctl(6'd58, 2'b10, 1'b1));
    step();
    check({30'b0, sts_o}, 32'd0, "no spurious expiry R11");
    // R2: extension field selects bit 5; bit 0 ignored
    cur_req = "R2"; bit0(0); bit0(1);
    check({30'b0, sts_o}, 32'd0, "unselected bit ignored R2");
    tbase[5] = 0; step(); tbase[5] = 1; step();
    check({30'b0, sts_o}, 32'd2, "bit 5 expiry R2");

    // random phase
    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      tbase = tbase + 64'($urandom_range(0, 3));
      wd_en = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 49) == 0)
        wr_ctl(mk_ctl({$urandom_range(0, 1) ? 4'hF : 4'hE, 2'($urandom_range(0, 3))},
                      2'($urandom_range(0, 3)), 1'($urandom_range(0, 1))));
      else begin
        if ($urandom_range(0, 19) == 0) begin
          sts_set_we = 1'($urandom_range(0, 1));
          sts_clr_we = 1'($urandom_range(0, 1));
          sts_wdata  = 2'($urandom_range(0, 3));
        end
        step();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule